// File: doc/BRIEF.md
# Indirect Double-Buffered Clock Configuration Registers

This block holds the divider settings that a clock generator reads. It also holds a small directly mapped register that chooses the audio clock source. The host never addresses the divider fields directly. It loads an index into an index register and a byte into a data register, then writes an operation code into a command register. Every indirect store goes into a staging bank that the clock logic cannot see. A commit operation moves the whole staging bank into the active bank on one clock edge, so downstream logic never receives a half-written configuration.

There are two parameter families, one for the 48 kHz sample-rate family and one for the 44.1 kHz family. Each family has three integer dividers (X, M, N) and a 16-bit fractional word. The fractional word is stored as two byte fields. When the processor start input is seen, the block sets a lock that cannot be cleared. From then on, stores and commits are refused, and a status bit reports each refusal. Reads through the indirection still work after the lock. The clock-source register also stays writable after the lock.

Top module: `clk_cfg_regs`

## Requirements
- R1: The direct register offsets are: index at 0x00, data at 0x01, command at 0x02 (bits 1:0), status at 0x03 and clock source at 0x12. Index, data and clock source read back what was written. Any other offset reads 0x00.
- R2: The command register executes on the clock edge after it is written. Code 0 does nothing, 1 stores, 2 fetches and 3 commits. The command register reads its written code for one cycle and then reads 0.
- R3: A store copies the data register into the staging field selected by the index. The active outputs do not change.
- R4: A fetch loads the data register with the staging field selected by the index. It does not read the active field.
- R5: A commit copies every staging field of both families into the active bank on a single edge. The outputs change only on the edge where the commit executes.
- R6: The index of family f, field k is f*8+k, where f=0 is the 48 kHz family. Field k is 0 for X, 1 for M, 2 for N, 3 for the fraction low byte and 4 for the fraction high byte. The fraction output of a family is 256*high+low. Family f occupies bits [f*8+:8] of each divider output and bits [f*16+:16] of the fraction output.
- R7: A store or fetch whose index is 16 or more, or whose field is 5 to 7, changes nothing. It sets status bit 0, which stays set until it is cleared.
- R8: A high procStart sets status bit 2 (the lock) on the next edge. The lock remains set until reset. While the lock is set, stores and commits have no effect and set status bit 1. Fetches still work.
- R9: Writing the status register clears bit 0 and bit 1 where the written byte has a 1. The lock bit cannot be cleared this way.
- R10: After reset, both banks hold the parameter defaults for every family. The index, data, command, status and clock-source registers read 0.
- R11: Bit 0 of the clock-source register drives clkSrcExt and bit 1 drives clkPinOe. Bits 7:2 read 0. The register stays writable after the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 8 | Direct register offset |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Read data for hostAddr (combinational) |
| procStart | input | 1 | Processor start; sets the lock |
| xDivOut | output | NUM_FAM*8 | Active X dividers |
| mDivOut | output | NUM_FAM*8 | Active M dividers |
| nDivOut | output | NUM_FAM*8 | Active N dividers |
| fracOut | output | NUM_FAM*16 | Active fraction words |
| clkSrcExt | output | 1 | 1 selects the external clock pin as the audio clock source |
| clkPinOe | output | 1 | Drive enable for the bidirectional clock pin |

## Verification
The main function is driven with distinct bytes in every field of both families. A wrong family offset, a swapped field or a swapped fraction byte therefore shows up on the outputs. The outputs are sampled on the cycle before and the cycle after a commit, which separates a correct single-edge commit from one that is early, late or partial. Indices just past the last field, inside the gap between families and beyond the last family separate field checks from range checks. Stores, commits and fetches issued after the start pulse separate the refused operations from the one that must still work.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  localparam int BYTE_W      = 8;
  localparam int FIELD_CNT   = 5;
  localparam int FAM_STRIDE  = 8;
  localparam int FIELD_SEL_W = $clog2(FAM_STRIDE);

  localparam int FLD_X  = 0;
  localparam int FLD_M  = 1;
  localparam int FLD_N  = 2;
  localparam int FLD_LO = 3;
  localparam int FLD_HI = 4;

  localparam logic [7:0] OFF_INDEX  = 8'h00;
  localparam logic [7:0] OFF_DATA   = 8'h01;
  localparam logic [7:0] OFF_CMD    = 8'h02;
  localparam logic [7:0] OFF_STATUS = 8'h03;
  localparam logic [7:0] OFF_CLKSRC = 8'h12;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_STORE = 2'd1,
    CMD_FETCH = 2'd2,
    CMD_APPLY = 2'd3
  } cmd_e;

  typedef struct packed {
    logic stageWr;
    logic stageRd;
    logic commit;
  } strobe_t;
endpackage

// File: rtl/clk_cfg_ctrl.sv
module clk_cfg_ctrl
  import clk_cfg_pkg::*;
#(
  parameter int NUM_FAM = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrEn,
  input  logic [1:0]  cmdWrVal,
  input  logic        statusWrEn,
  input  logic [2:0]  statusClr,
  input  logic        procStart,
  input  logic [7:0]  curIdx,
  output cmd_e        cmdReg,
  output logic        errFlag,
  output logic        rejFlag,
  output logic        lockFlag,
  output strobe_t     stb
);
  localparam int IDX_LIMIT = NUM_FAM * FAM_STRIDE;

  logic idxOk;
  logic lockedOp;
  logic badIdx;

  // decode the pending command against the lock and the index range
  always_comb begin
    idxOk    = (int'(curIdx) < IDX_LIMIT) &&
               (int'(curIdx[FIELD_SEL_W-1:0]) < FIELD_CNT);
    stb      = '0;
    lockedOp = 1'b0;
    badIdx   = 1'b0;
    case (cmdReg)
      CMD_STORE: begin
        if (lockFlag)      lockedOp    = 1'b1;
        else if (!idxOk)   badIdx      = 1'b1;
        else               stb.stageWr = 1'b1;
      end
      CMD_FETCH: begin
        if (!idxOk)        badIdx      = 1'b1;
        else               stb.stageRd = 1'b1;
      end
      CMD_APPLY: begin
        if (lockFlag)      lockedOp    = 1'b1;
        else               stb.commit  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= CMD_IDLE;
      errFlag  <= 1'b0;
      rejFlag  <= 1'b0;
      lockFlag <= 1'b0;
    end else begin
      cmdReg   <= cmdWrEn ? cmd_e'(cmdWrVal) : CMD_IDLE;
      errFlag  <= badIdx   | (errFlag & ~(statusWrEn & statusClr[0]));
      rejFlag  <= lockedOp | (rejFlag & ~(statusWrEn & statusClr[1]));
      lockFlag <= lockFlag | procStart;
    end
  end
endmodule

// File: rtl/clk_cfg_dpath.sv
module clk_cfg_dpath
  import clk_cfg_pkg::*;
#(
  parameter int          NUM_FAM  = 2,
  parameter logic [7:0]  DEF_XDIV = 8'd1,
  parameter logic [7:0]  DEF_MDIV = 8'd3,
  parameter logic [7:0]  DEF_NDIV = 8'd24,
  parameter logic [15:0] DEF_FRAC = 16'h4000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    idxWrEn,
  input  logic [7:0]              idxWrVal,
  input  logic                    dataWrEn,
  input  logic [7:0]              dataWrVal,
  input  logic                    srcWrEn,
  input  logic [1:0]              srcWrVal,
  input  strobe_t                 stb,
  output logic [7:0]              idxReg,
  output logic [7:0]              dataReg,
  output logic [1:0]              srcReg,
  output logic [NUM_FAM*8-1:0]    xDivOut,
  output logic [NUM_FAM*8-1:0]    mDivOut,
  output logic [NUM_FAM*8-1:0]    nDivOut,
  output logic [NUM_FAM*16-1:0]   fracOut
);
  localparam int FAM_W    = (NUM_FAM > 1) ? $clog2(NUM_FAM) : 1;
  localparam int SLOT_CNT = NUM_FAM * FIELD_CNT;

  logic [FAM_W-1:0]          famSel;
  logic [FIELD_SEL_W-1:0]    fldSel;
  logic [SLOT_CNT*8-1:0]     stageFlat;
  logic [7:0]                fetchVal;

  assign famSel = idxReg[FIELD_SEL_W +: FAM_W];
  assign fldSel = idxReg[FIELD_SEL_W-1:0];

  function automatic logic [7:0] defByte(input int k);
    case (k)
      FLD_X:   return DEF_XDIV;
      FLD_M:   return DEF_MDIV;
      FLD_N:   return DEF_NDIV;
      FLD_LO:  return DEF_FRAC[7:0];
      default: return DEF_FRAC[15:8];
    endcase
  endfunction

  for (genvar f = 0; f < NUM_FAM; f++) begin : g_fam
    logic [7:0] actByte [FIELD_CNT];
    for (genvar k = 0; k < FIELD_CNT; k++) begin : g_fld
      logic       hit;
      logic [7:0] stageQ;
      logic [7:0] actQ;
      assign hit = (famSel == FAM_W'(f)) && (fldSel == FIELD_SEL_W'(k));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stageQ <= defByte(k);
          actQ   <= defByte(k);
        end else begin
          if (stb.stageWr && hit) stageQ <= dataReg;
          if (stb.commit)         actQ   <= stageQ;
        end
      end
      assign stageFlat[(f*FIELD_CNT+k)*8 +: 8] = stageQ;
      assign actByte[k] = actQ;
    end
    assign xDivOut[f*8 +: 8]   = actByte[FLD_X];
    assign mDivOut[f*8 +: 8]   = actByte[FLD_M];
    assign nDivOut[f*8 +: 8]   = actByte[FLD_N];
    assign fracOut[f*16 +: 16] = {actByte[FLD_HI], actByte[FLD_LO]};
  end

  // staging byte picked by the current index
  always_comb begin
    fetchVal = '0;
    for (int f = 0; f < NUM_FAM; f++) begin
      for (int k = 0; k < FIELD_CNT; k++) begin
        if (famSel == FAM_W'(f) && fldSel == FIELD_SEL_W'(k))
          fetchVal = stageFlat[(f*FIELD_CNT+k)*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg  <= '0;
      dataReg <= '0;
      srcReg  <= '0;
    end else begin
      if (idxWrEn) idxReg <= idxWrVal;
      if (stb.stageRd)   dataReg <= fetchVal;
      else if (dataWrEn) dataReg <= dataWrVal;
      if (srcWrEn) srcReg <= srcWrVal;
    end
  end
endmodule

// File: rtl/clk_cfg_regs.sv
module clk_cfg_regs
  import clk_cfg_pkg::*;
#(
  parameter int          NUM_FAM  = 2,
  parameter logic [7:0]  DEF_XDIV = 8'd1,
  parameter logic [7:0]  DEF_MDIV = 8'd3,
  parameter logic [7:0]  DEF_NDIV = 8'd24,
  parameter logic [15:0] DEF_FRAC = 16'h4000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             hostAddr,
  input  logic                   hostWrEn,
  input  logic [7:0]             hostWrData,
  output logic [7:0]             hostRdData,
  input  logic                   procStart,
  output logic [NUM_FAM*8-1:0]   xDivOut,
  output logic [NUM_FAM*8-1:0]   mDivOut,
  output logic [NUM_FAM*8-1:0]   nDivOut,
  output logic [NUM_FAM*16-1:0]  fracOut,
  output logic                   clkSrcExt,
  output logic                   clkPinOe
);
  logic       idxWrEn, dataWrEn, cmdWrEn, statusWrEn, srcWrEn;
  logic [7:0] idxReg, dataReg;
  logic [1:0] srcReg;
  cmd_e       cmdReg;
  logic       errFlag, rejFlag, lockFlag;
  strobe_t    stb;
  logic       unusedWrBits;

  assign idxWrEn      = hostWrEn && (hostAddr == OFF_INDEX);
  assign dataWrEn     = hostWrEn && (hostAddr == OFF_DATA);
  assign cmdWrEn      = hostWrEn && (hostAddr == OFF_CMD);
  assign statusWrEn   = hostWrEn && (hostAddr == OFF_STATUS);
  assign srcWrEn      = hostWrEn && (hostAddr == OFF_CLKSRC);
  assign unusedWrBits = ^hostWrData[7:3];

  clk_cfg_ctrl #(.NUM_FAM(NUM_FAM)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdWrEn    (cmdWrEn),
    .cmdWrVal   (hostWrData[1:0]),
    .statusWrEn (statusWrEn),
    .statusClr  (hostWrData[2:0]),
    .procStart  (procStart),
    .curIdx     (idxReg),
    .cmdReg     (cmdReg),
    .errFlag    (errFlag),
    .rejFlag    (rejFlag),
    .lockFlag   (lockFlag),
    .stb        (stb)
  );

  clk_cfg_dpath #(
    .NUM_FAM  (NUM_FAM),
    .DEF_XDIV (DEF_XDIV),
    .DEF_MDIV (DEF_MDIV),
    .DEF_NDIV (DEF_NDIV),
    .DEF_FRAC (DEF_FRAC)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .idxWrEn   (idxWrEn),
    .idxWrVal  (hostWrData),
    .dataWrEn  (dataWrEn),
    .dataWrVal (hostWrData),
    .srcWrEn   (srcWrEn),
    .srcWrVal  (hostWrData[1:0]),
    .stb       (stb),
    .idxReg    (idxReg),
    .dataReg   (dataReg),
    .srcReg    (srcReg),
    .xDivOut   (xDivOut),
    .mDivOut   (mDivOut),
    .nDivOut   (nDivOut),
    .fracOut   (fracOut)
  );

  always_comb begin
    case (hostAddr)
      OFF_INDEX:  hostRdData = idxReg;
      OFF_DATA:   hostRdData = dataReg;
      OFF_CMD:    hostRdData = {6'b0, cmdReg};
      OFF_STATUS: hostRdData = {5'b0, lockFlag, rejFlag, errFlag};
      OFF_CLKSRC: hostRdData = {6'b0, srcReg};
      default:    hostRdData = 8'h00;
    endcase
  end

  assign clkSrcExt = srcReg[0];
  assign clkPinOe  = srcReg[1];
endmodule

// File: rtl/clk_cfg_chk.sv
module clk_cfg_chk
  import clk_cfg_pkg::*;
#(
  parameter int NUM_FAM = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [7:0]             hostAddr,
  input logic                   hostWrEn,
  input logic                   errClrBit,
  input logic [7:0]             hostRdData,
  input cmd_e                   cmdReg,
  input strobe_t                stb,
  input logic                   errFlag,
  input logic                   lockFlag,
  input logic [NUM_FAM*8-1:0]   xDivOut,
  input logic [NUM_FAM*8-1:0]   mDivOut,
  input logic [NUM_FAM*8-1:0]   nDivOut,
  input logic [NUM_FAM*16-1:0]  fracOut
);
  AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReg != CMD_IDLE && !(hostWrEn && hostAddr == OFF_CMD)) |=> (cmdReg == CMD_IDLE)) // R2
    else $error("command did not clear");

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.stageWr, stb.stageRd, stb.commit})) // R2
    else $error("more than one action strobe");

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> ($stable(xDivOut) && $stable(mDivOut) && $stable(nDivOut) && $stable(fracOut))) // R5
    else $error("active bank moved without commit");

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lockFlag |=> lockFlag) // R8
    else $error("lock dropped");

  AST_LOCK_GATES: assert property (@(posedge clk) disable iff (!rstN)
    lockFlag |-> (!stb.stageWr && !stb.commit)) // R8
    else $error("store or commit while locked");

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(hostWrEn && hostAddr == OFF_STATUS && errClrBit)) |=> errFlag) // R7
    else $error("error flag lost");

  AST_SRC_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == OFF_CLKSRC) |-> (hostRdData[7:2] == 6'b0)) // R11
    else $error("clock source upper bits not zero");
endmodule

bind clk_cfg_regs clk_cfg_chk #(.NUM_FAM(NUM_FAM)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostAddr   (hostAddr),
  .hostWrEn   (hostWrEn),
  .errClrBit  (hostWrData[0]),
  .hostRdData (hostRdData),
  .cmdReg     (cmdReg),
  .stb        (stb),
  .errFlag    (errFlag),
  .lockFlag   (lockFlag),
  .xDivOut    (xDivOut),
  .mDivOut    (mDivOut),
  .nDivOut    (nDivOut),
  .fracOut    (fracOut)
);

// File: tb/clk_cfg_regs_bench.sv
`timescale 1ns/1ps
module clk_cfg_regs_bench;
  localparam int          NF = 2;
  localparam logic [7:0]  DX = 8'd1;
  localparam logic [7:0]  DM = 8'd3;
  localparam logic [7:0]  DN = 8'd24;
  localparam logic [15:0] DF = 16'h4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] hostAddr = 8'h00;
  logic hostWrEn = 1'b0;
  logic [7:0] hostWrData = 8'h00;
  logic [7:0] hostRdData;
  logic procStart = 1'b0;
  logic [NF*8-1:0]  xDivOut, mDivOut, nDivOut;
  logic [NF*16-1:0] fracOut;
  logic clkSrcExt, clkPinOe;

  always #4 clk = ~clk;

  clk_cfg_regs #(.NUM_FAM(NF), .DEF_XDIV(DX), .DEF_MDIV(DM), .DEF_NDIV(DN), .DEF_FRAC(DF)) u_clk_cfg_regs (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .procStart(procStart), .xDivOut(xDivOut), .mDivOut(mDivOut),
    .nDivOut(nDivOut), .fracOut(fracOut), .clkSrcExt(clkSrcExt), .clkPinOe(clkPinOe));

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference model
  logic [7:0] mStage [NF][5];
  logic [7:0] mAct   [NF][5];
  logic [7:0] mIdx, mData;
  logic [1:0] mCmd, mSrc;
  logic mErr, mRej, mLock;

  function automatic logic [7:0] defOf(input int k);
    case (k)
      0: return DX;
      1: return DM;
      2: return DN;
      3: return DF[7:0];
      default: return DF[15:8];
    endcase
  endfunction

  task automatic modelReset();
    for (int f = 0; f < NF; f++)
      for (int k = 0; k < 5; k++) begin
        mStage[f][k] = defOf(k);
        mAct[f][k]   = defOf(k);
      end
    mIdx = 0; mData = 0; mCmd = 0; mSrc = 0; mErr = 0; mRej = 0; mLock = 0;
  endtask

  task automatic modelStep();
    logic [7:0] oIdx  = mIdx;
    logic [7:0] oData = mData;
    logic [1:0] oCmd  = mCmd;
    logic       oLock = mLock;
    int  f  = oIdx / 8;
    int  k  = oIdx % 8;
    bit  ok = (oIdx < NF*8) && (k < 5);
    mCmd = 0;
    if (hostWrEn) begin
      case (hostAddr)
        8'h00: mIdx  = hostWrData;
        8'h01: mData = hostWrData;
        8'h02: mCmd  = hostWrData[1:0];
        8'h03: begin
          if (hostWrData[0]) mErr = 0;
          if (hostWrData[1]) mRej = 0;
        end
        8'h12: mSrc = hostWrData[1:0];
        default: ;
      endcase
    end
    case (oCmd)
      2'd1: if (oLock) mRej = 1; else if (!ok) mErr = 1; else mStage[f][k] = oData;
      2'd2: if (!ok) mErr = 1; else mData = mStage[f][k];
      2'd3: if (oLock) mRej = 1;
            else for (int a = 0; a < NF; a++) for (int b = 0; b < 5; b++) mAct[a][b] = mStage[a][b];
      default: ;
    endcase
    if (procStart) mLock = 1;
  endtask

  function automatic logic [7:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00: return mIdx;
      8'h01: return mData;
      8'h02: return {6'b0, mCmd};
      8'h03: return {5'b0, mLock, mRej, mErr};
      8'h12: return {6'b0, mSrc};
      default: return 8'h00;
    endcase
  endfunction

  initial modelReset();
  always @(posedge clk) begin
    if (!rstN) modelReset();
    else modelStep();
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison of every output against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [NF*8-1:0]  ex, em, en;
      logic [NF*16-1:0] ef;
      for (int f = 0; f < NF; f++) begin
        ex[f*8 +: 8]   = mAct[f][0];
        em[f*8 +: 8]   = mAct[f][1];
        en[f*8 +: 8]   = mAct[f][2];
        ef[f*16 +: 16] = {mAct[f][4], mAct[f][3]};
      end
      chk("R3 R5 R6 xDiv per cycle", 64'(xDivOut), 64'(ex));
      chk("R3 R5 R6 mDiv per cycle", 64'(mDivOut), 64'(em));
      chk("R3 R5 R6 nDiv per cycle", 64'(nDivOut), 64'(en));
      chk("R5 R6 frac per cycle", 64'(fracOut), 64'(ef));
      chk("R11 clock pins per cycle", 64'({clkPinOe, clkSrcExt}), 64'(mSrc));
    end
  end

  task automatic hw(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic rdNow(input logic [7:0] a, input string tag, output logic [7:0] v);
    hostAddr = a;
    #1;
    v = hostRdData;
    chk(tag, 64'(v), 64'(modelRead(a)));
  endtask

  task automatic rd(input logic [7:0] a, input string tag, output logic [7:0] v);
    @(negedge clk);
    rdNow(a, tag, v);
  endtask

  task automatic ind(input logic [1:0] c, input logic [7:0] idx, input logic [7:0] d);
    hw(8'h00, idx);
    hw(8'h01, d);
    hw(8'h02, {6'b0, c});
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    rd(8'h00, "R10 index after reset", v); chk("R10 index zero", 64'(v), 64'h0);
    rd(8'h01, "R10 data after reset", v);  chk("R10 data zero", 64'(v), 64'h0);
    rd(8'h02, "R10 cmd after reset", v);   chk("R10 cmd zero", 64'(v), 64'h0);
    rd(8'h03, "R10 status after reset", v); chk("R10 status zero", 64'(v), 64'h0);
    rd(8'h12, "R10 clksrc after reset", v); chk("R10 clksrc zero", 64'(v), 64'h0);
    chk("R10 default X", 64'(xDivOut), 64'({DX, DX}));
    chk("R10 default frac", 64'(fracOut), 64'({DF, DF}));

    // R2 self-clearing command, R3 store
    hw(8'h00, 8'h00); hw(8'h01, 8'h11); hw(8'h02, 8'h01);
    rdNow(8'h02, "R2 cmd visible", v); chk("R2 cmd holds code", 64'(v), 64'h1);
    rd(8'h02, "R2 cmd cleared", v);    chk("R2 cmd reads zero", 64'(v), 64'h0);
    ind(2'd1, 8'h01, 8'h22); ind(2'd1, 8'h02, 8'h33);
    ind(2'd1, 8'h03, 8'h44); ind(2'd1, 8'h04, 8'h55);
    for (int k = 0; k < 5; k++) ind(2'd1, 8'(8 + k), 8'(8'h66 + 8'(k) * 8'h11));
    chk("R3 staging hidden from X", 64'(xDivOut), 64'({DX, DX}));

    // R4 fetch from staging
    ind(2'd2, 8'h03, 8'h00); rd(8'h01, "R4 fetch lo", v); chk("R4 fetched 0x44", 64'(v), 64'h44);
    ind(2'd2, 8'h0C, 8'h00); rd(8'h01, "R4 fetch hi", v); chk("R4 fetched 0xAA", 64'(v), 64'hAA);

    // R5 R6 commit timing and layout
    hw(8'h02, 8'h03);
    chk("R5 before commit edge", 64'(xDivOut), 64'({DX, DX}));
    @(negedge clk);
    chk("R5 R6 X after commit", 64'(xDivOut), 64'h6611);
    chk("R6 M after commit", 64'(mDivOut), 64'h7722);
    chk("R6 N after commit", 64'(nDivOut), 64'h8833);
    chk("R6 frac after commit", 64'(fracOut), 64'hAA99_5544);

    // R7 bad indices
    ind(2'd1, 8'h05, 8'hEE); rd(8'h03, "R7 status field gap", v); chk("R7 err set", 64'(v), 64'h01);
    ind(2'd2, 8'h04, 8'h00); rd(8'h01, "R7 neighbour intact", v); chk("R7 hi byte unchanged", 64'(v), 64'h55);
    ind(2'd1, 8'h0D, 8'hEE); ind(2'd1, 8'h20, 8'hEE);
    ind(2'd2, 8'h20, 8'h00); rd(8'h01, "R7 fetch out of range", v); chk("R7 data kept", 64'(v), 64'h00);
    rd(8'h03, "R7 err sticky", v); chk("R7 err still set", 64'(v), 64'h01);

    // R9 write-one-to-clear
    hw(8'h03, 8'h02); rd(8'h03, "R9 wrong bit", v); chk("R9 err kept", 64'(v), 64'h01);
    hw(8'h03, 8'h01); rd(8'h03, "R9 clear err", v); chk("R9 status zero", 64'(v), 64'h00);

    // R11 R1 clock source and unmapped offset
    hw(8'h12, 8'hFF); rd(8'h12, "R11 clksrc read", v); chk("R11 upper bits zero", 64'(v), 64'h03);
    chk("R11 pins both set", 64'({clkPinOe, clkSrcExt}), 64'h3);
    hw(8'h12, 8'h02); chk("R11 pin oe only", 64'({clkPinOe, clkSrcExt}), 64'h2);
    rd(8'h40, "R1 unmapped", v); chk("R1 unmapped zero", 64'(v), 64'h00);
    rd(8'h00, "R1 index readback", v);

    // R8 lock
    ind(2'd1, 8'h01, 8'h5A);
    @(negedge clk); procStart = 1'b1;
    @(negedge clk); procStart = 1'b0;
    rd(8'h03, "R8 lock set", v); chk("R8 lock bit", 64'(v), 64'h04);
    ind(2'd1, 8'h00, 8'h99); rd(8'h03, "R8 store refused", v); chk("R8 reject bit", 64'(v), 64'h06);
    ind(2'd3, 8'h00, 8'h00);
    chk("R8 commit refused", 64'(mDivOut), 64'h7722);
    ind(2'd2, 8'h01, 8'h00); rd(8'h01, "R8 fetch works", v); chk("R8 fetched 0x5A", 64'(v), 64'h5A);
    ind(2'd2, 8'h00, 8'h00); rd(8'h01, "R8 store had no effect", v); chk("R8 X staging 0x11", 64'(v), 64'h11);
    hw(8'h03, 8'h07); rd(8'h03, "R9 lock not clearable", v); chk("R9 lock kept", 64'(v), 64'h04);
    hw(8'h12, 8'h01); rd(8'h12, "R11 writable when locked", v); chk("R11 clksrc 1", 64'(v), 64'h01);

    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule